// File: doc/BRIEF.md
# Packed Dual-MAC Dot Product Engine

The engine computes the dot product of a coefficient vector and a data vector kept in two word-wide memories. Each 32-bit word packs two signed 16-bit elements of the vector. After a start pulse, the engine reads one coefficient word and one data word per cycle. Two multipliers work in parallel, one on the low halves and one on the high halves, so each loop step performs two multiply-accumulates.

Low-half products (even-indexed elements) build up in one accumulator and high-half products (odd-indexed elements) in a second one. When the last products have drained through the load and multiply pipeline, the two partial sums are added. The low 16 bits of that total are presented as the result, together with a one-cycle done flag.

A fixed load latency is assumed for both memories. Internal valid tracking lines the returning words up with the cycle in which they were requested.

Top module: `dotp_engine`

## Requirements
- R1: After reset, `done`, `coef_rd` and `data_rd` are low and `result` is zero.
- R2: A `start` pulse while idle is accepted and captures `vec_len`; the pair count is `vec_len >> 1`, so the least significant bit of `vec_len` is ignored.
- R3: A run with P pairs raises `coef_rd` and `data_rd` together for exactly P consecutive cycles, with both addresses equal and stepping 0, 1, ..., P-1.
- R4: The read word for a strobe in cycle t is taken from the read data ports in cycle t+LOAD_LAT (LOAD_LAT = 4 by default).
- R5: In each word, bits [15:0] hold even element 2k and bits [31:16] hold odd element 2k+1, both signed two's complement; low halves are multiplied together and high halves are multiplied together.
- R6: `result` equals the low 16 bits of the sum over all 2P elements of coefficient times data, with two's complement wrap.
- R7: `done` is high for exactly one cycle per run; `result` changes only in that cycle and holds its value until the next `done`.
- R8: For P >= 1, `done` is high in cycle s+P+7, where s is the cycle in which the accepted `start` was high.
- R9: A run with P = 0 issues no reads and gives `done` in cycle s+3 with `result` zero.
- R10: A `start` pulse while a run is busy is ignored: the strobe count, the result and the done timing of the running job are unchanged.
- R11: Both accumulators are cleared when a start is accepted, so a result never depends on an earlier run.
- R12: Values on the read data ports outside the cycles named in R4 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, honoured only while idle |
| vec_len | input | LEN_W | Vector length in elements (even) |
| coef_rd | output | 1 | Coefficient read strobe |
| coef_addr | output | ADDR_W | Coefficient word address |
| coef_rdata | input | 32 | Coefficient word, LOAD_LAT cycles after strobe |
| data_rd | output | 1 | Data read strobe |
| data_addr | output | ADDR_W | Data word address |
| data_rdata | input | 32 | Data word, LOAD_LAT cycles after strobe |
| result | output | 16 | Low 16 bits of the dot product |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the engine with ADDR_W = 4, LEN_W = 6, LOAD_LAT = 4 and ACC_W = 40. With that configuration every vector length from 0 to 33 elements can be run, reaching the whole 16-word address space, under four operand patterns, including full-scale negative halves whose sums overflow 16 bits. The small length field also lets a busy-time start and odd lengths be tried at every size. Between strobes the bench drives changing junk on the read data ports, so a word sampled in the wrong cycle shows up as a wrong result.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PROD_W = 2 * HALF_W;

  typedef logic signed [HALF_W-1:0] half_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  typedef struct packed {
    half_t odd_e;
    half_t even_e;
  } pair_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  function automatic prod_t half_mul(input half_t a, input half_t b);
    return prod_t'(a) * prod_t'(b);
  endfunction

  function automatic half_t trim_total(input logic [WORD_W+15:0] total);
    return half_t'(total[HALF_W-1:0]);
  endfunction
endpackage

// File: rtl/dotp_issue.sv
module dotp_issue
  import dotp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic              drained,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accept,
  output logic              finish
);
  localparam int PAIR_W = LEN_W - 1;

  phase_t            phase;
  logic [PAIR_W-1:0] remain;
  logic [ADDR_W-1:0] addr_q;

  assign accept  = (phase == PH_IDLE) && start;
  assign rd_fire = (phase == PH_ISSUE) && (remain != '0);
  assign finish  = (phase == PH_DRAIN) && drained;
  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
      addr_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            remain <= vec_len[LEN_W-1:1];
            addr_q <= '0;
            phase  <= PH_ISSUE;
          end
        end
        PH_ISSUE: begin
          if (remain != '0) begin
            addr_q <= addr_q + 1'b1;
            remain <= remain - 1'b1;
            if (remain == PAIR_W'(1)) phase <= PH_DRAIN;
          end else begin
            phase <= PH_DRAIN;
          end
        end
        PH_DRAIN: begin
          if (drained) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: back-to-back strobes walk consecutive word addresses
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && $past(rd_fire)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R2: an accepted start begins issuing at word zero
  a_r2_begin_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_ISSUE && rd_addr == '0));

  // R10: a start seen while issuing does not reload the pair counter
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ISSUE && start && remain > PAIR_W'(1)) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/dotp_lanes.sv
module dotp_lanes
  import dotp_pkg::*;
#(
  parameter int LOAD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [WORD_W-1:0] coef_word,
  input  logic [WORD_W-1:0] data_word,
  output logic              load_vld,
  output logic              prod_vld,
  output prod_t             prod_even,
  output prod_t             prod_odd,
  output logic              inflight
);
  logic [LOAD_LAT-1:0] vld_pipe;
  pair_t               cw;
  pair_t               dw;

  generate
    if (LOAD_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= rd_fire;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LOAD_LAT-2:0], rd_fire};
      end
    end
  endgenerate

  assign load_vld = vld_pipe[LOAD_LAT-1];
  assign cw       = pair_t'(coef_word);
  assign dw       = pair_t'(data_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_vld  <= 1'b0;
      prod_even <= '0;
      prod_odd  <= '0;
    end else begin
      prod_vld <= load_vld;
      if (load_vld) begin
        prod_even <= half_mul(cw.even_e, dw.even_e);
        prod_odd  <= half_mul(cw.odd_e, dw.odd_e);
      end
    end
  end

  assign inflight = (|vld_pipe) | prod_vld;

  // R4: a product is only ever formed from a word in its load-valid cycle
  a_r4_prod_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |-> $past(load_vld));

  // R4: a load returns only if a strobe was issued earlier
  a_r4_load_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_vld) |-> $past(inflight));
endmodule

// File: rtl/dotp_accum.sv
module dotp_accum
  import dotp_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  prod_vld,
  input  prod_t prod_even,
  input  prod_t prod_odd,
  input  logic  finish,
  output half_t result,
  output logic  done
);
  logic signed [ACC_W-1:0] acc_even;
  logic signed [ACC_W-1:0] acc_odd;
  logic signed [ACC_W-1:0] total;

  assign total = acc_even + acc_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_even <= '0;
      acc_odd  <= '0;
      result   <= '0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (clear) begin
        acc_even <= '0;
        acc_odd  <= '0;
      end else if (prod_vld) begin
        acc_even <= acc_even + ACC_W'(prod_even);
        acc_odd  <= acc_odd + ACC_W'(prod_odd);
      end
      if (finish) result <= trim_total((WORD_W+16)'(total));
    end
  end

  // R11: accepting a start empties both partial sums
  a_r11_clear_sums: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_even == '0 && acc_odd == '0));

  // R7: completion flag lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the result only moves together with done
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: rtl/dotp_engine.sv
module dotp_engine
  import dotp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LEN_W    = 9,
  parameter int LOAD_LAT = 4,
  parameter int ACC_W    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  vec_len,
  output logic              coef_rd,
  output logic [ADDR_W-1:0] coef_addr,
  input  logic [31:0]       coef_rdata,
  output logic              data_rd,
  output logic [ADDR_W-1:0] data_addr,
  input  logic [31:0]       data_rdata,
  output logic [15:0]       result,
  output logic              done
);
  logic              rd_fire;
  logic [ADDR_W-1:0] rd_addr;
  logic              accept;
  logic              finish;
  logic              load_vld;
  logic              prod_vld;
  prod_t             prod_even;
  prod_t             prod_odd;
  logic              inflight;
  half_t             result_s;

  dotp_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vec_len (vec_len),
    .drained (!inflight),
    .rd_fire (rd_fire),
    .rd_addr (rd_addr),
    .accept  (accept),
    .finish  (finish)
  );

  dotp_lanes #(.LOAD_LAT(LOAD_LAT)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .coef_word (coef_rdata),
    .data_word (data_rdata),
    .load_vld  (load_vld),
    .prod_vld  (prod_vld),
    .prod_even (prod_even),
    .prod_odd  (prod_odd),
    .inflight  (inflight)
  );

  dotp_accum #(.ACC_W(ACC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .prod_vld  (prod_vld),
    .prod_even (prod_even),
    .prod_odd  (prod_odd),
    .finish    (finish),
    .result    (result_s),
    .done      (done)
  );

  assign coef_rd   = rd_fire;
  assign data_rd   = rd_fire;
  assign coef_addr = rd_addr;
  assign data_addr = rd_addr;
  assign result    = result_s;

  // R8: completion is never flagged while products are still in flight
  a_r8_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!inflight));

  // R3: no strobe while a result is being reported
  a_r3_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !coef_rd);
endmodule

// File: tb/test_dotp_engine.sv
module test_dotp_engine;
  localparam int ADDR_W = 4;
  localparam int LEN_W  = 6;
  localparam int LAT    = 4;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  vec_len = '0;
  logic              coef_rd, data_rd, done;
  logic [ADDR_W-1:0] coef_addr, data_addr;
  logic [31:0]       coef_rdata, data_rdata;
  logic [15:0]       result;

  logic [31:0] coef_mem [WORDS];
  logic [31:0] data_mem [WORDS];
  logic [31:0] cpipe [LAT];
  logic [31:0] dpipe [LAT];
  int cyc = 0;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dotp_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOAD_LAT(LAT), .ACC_W(40)) i_dotp_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
    .coef_rd(coef_rd), .coef_addr(coef_addr), .coef_rdata(coef_rdata),
    .data_rd(data_rd), .data_addr(data_addr), .data_rdata(data_rdata),
    .result(result), .done(done));

  // Memory model: word requested in cycle t is on the port in cycle t+LAT, junk otherwise (R4, R12)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int k = LAT - 1; k > 0; k--) begin
      cpipe[k] <= cpipe[k-1];
      dpipe[k] <= dpipe[k-1];
    end
    cpipe[0] <= coef_rd ? coef_mem[coef_addr] : (32'hA5C3_5A3C ^ cyc);
    dpipe[0] <= data_rd ? data_mem[data_addr] : (32'h3C96_C369 + cyc * 7);
  end
  assign coef_rdata = cpipe[LAT-1];
  assign data_rdata = dpipe[LAT-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int p, input int i);
    logic [31:0] v;
    case (p)
      0: v = 32'h8000_8000;
      1: v = (i % 2 == 0) ? 32'h7FFF_FFFF : 32'h8001_7FFF;
      2: v = {16'(i * 1103 - 700), 16'(-i * 37 + 5)};
      default: v = 32'(i * 32'h9E37_79B9 + 32'h1234_5678);
    endcase
    return v;
  endfunction

  // Element e of a packed vector: even index in bits [15:0], odd in [31:16] (R5)
  function automatic longint elem(input logic [31:0] w, input int e);
    logic signed [15:0] h;
    h = (e % 2 == 0) ? w[15:0] : w[31:16];
    return longint'(h);
  endfunction

  task automatic run(input int len, input int p, input bit disturb);
    int pairs, strobes, s, lat;
    bit got;
    longint sum;
    logic [15:0] expv, held;
    for (int i = 0; i < WORDS; i++) begin
      coef_mem[i] = pattern(p, i);
      data_mem[i] = pattern((p + 1) % 4, i + 3);
    end
    pairs = len / 2;
    sum = 0;
    for (int e = 0; e < 2 * pairs; e++)
      sum += elem(coef_mem[e / 2], e) * elem(data_mem[e / 2], e);
    expv = sum[15:0];

    @(negedge clk);
    start = 1'b1; vec_len = LEN_W'(len); s = cyc;
    @(negedge clk);
    start = 1'b0;
    strobes = 0; got = 0; lat = 0;
    for (int w = 0; w < 200 && !got; w++) begin
      if (coef_rd || data_rd) begin
        chk(coef_rd && data_rd && coef_addr == data_addr && int'(coef_addr) == strobes,
            "R3", "strobe address", longint'(coef_addr), longint'(strobes));
        strobes++;
      end
      if (done) begin
        got = 1; lat = cyc - s;
      end
      if (disturb && w == 2) begin
        start = 1'b1; vec_len = LEN_W'(2);
      end else begin
        start = 1'b0;
      end
      if (!got) @(negedge clk);
    end
    start = 1'b0;
    chk(got, "R7", "done seen", longint'(got), 1);
    chk(strobes == pairs, disturb ? "R10" : "R3", "strobe count", strobes, pairs);
    chk(result == expv, pairs == 0 ? "R9" : (disturb ? "R10" : "R6"), "result",
        longint'(result), longint'(expv));
    if (pairs == 0) chk(lat == 3, "R9", "latency", lat, 3);
    else chk(lat == pairs + 7, "R8", "latency", lat, pairs + 7);
    held = result;
    @(negedge clk);
    chk(!done, "R7", "done width", longint'(done), 0);
    @(negedge clk);
    chk(result == held, "R7", "result held", longint'(result), longint'(held));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < LAT; k++) begin cpipe[k] = '0; dpipe[k] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!done && !coef_rd && !data_rd, "R1", "strobes/done at reset", longint'(done), 0);
    chk(result == 16'd0, "R1", "result at reset", longint'(result), 0);
    rst_n = 1'b1;
    // R2 (odd lengths drop their last element), R5, R6, R8, R9, R12 across all sizes
    for (int p = 0; p < 4; p++)
      for (int len = 0; len <= 2 * WORDS + 1; len++)
        run(len, p, 1'b0);
    // R10: start pulses while busy
    for (int len = 4; len <= 2 * WORDS; len += 6) run(len, 3, 1'b1);
    // R11: a short run right after a long one carries nothing over
    run(2 * WORDS, 0, 1'b0);
    run(2, 2, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule